// File: doc/BRIEF.md
# In-Array Row Copy Engine

This block models a DRAM-style bit array, organised as rows and columns, that can copy one whole row into another inside the array without moving any data across the port. Every access opens a row: the row is sensed into a row-wide latch and then written back. For ordinary accesses that write-back acts as a refresh of the same row. A copy command adds a row-wide holding register and a write-back selector. The copy uses two array cycles. In the first cycle the source row is opened, and the sensed data lands in both the latch and the holding register. In the second cycle the destination row is opened with write-select high, so that the holding register, not the latch, is written into the destination row.

Software-visible access is deliberately minimal. A single-bit column port reads or writes one cell by row and column, and exists for loading and inspecting the array. A command strobe carries the source and destination row numbers. Status comes back as busy, a one-clock done pulse and a one-clock error pulse. The array size is set by two parameters. The default is 16 by 16 so that elaboration stays small. Setting N_ROWS and N_COLS to 1024 gives a 1M x 1 array with a 10-bit row address.

The controller is a five-state machine:
- IDLE accepts commands and test accesses.
- IDLE moves to SRC_OPEN on a command whose two rows differ.
- IDLE moves to REJECT on a command whose two rows are equal.
- SRC_OPEN always moves to DST_OPEN.
- DST_OPEN always moves to FINISH.
- FINISH and REJECT both return to IDLE.

Top module: `rowcopy_engine`

## Requirements
- R1: While reset is held and just after it is released, busy, done, err and tst_ack are all 0.
- R2: In IDLE with cmd_valid low, a tst_req access to (tst_row, tst_col) is taken at the clock edge. tst_ack is 1 for the following cycle. tst_rdata then shows the bit the cell held before this access. When tst_we is 1, the cell takes tst_wbit and every other cell of that row keeps its value.
- R3: After a copy command with src different from dst completes, every bit of the destination row equals the source row as it stood when the command was taken.
- R4: busy is 1 from the cycle after the command edge (SRC_OPEN) through DST_OPEN and FINISH. done is 1 for exactly one cycle, in FINISH, which is the third cycle after the command edge. busy is 0 again in the cycle after that.
- R5: A copy leaves the source row and every row other than the destination unchanged.
- R6: cmd_valid while busy is 1 is ignored: the running copy keeps its rows and timing, and no second copy starts.
- R7: A command with src equal to dst raises err and busy for exactly one cycle (REJECT), never raises done, and changes no cell.
- R8: tst_req while busy is 1 produces no tst_ack and writes no cell.
- R9: When cmd_valid and tst_req are both high in IDLE, the command is taken and the test access is dropped (no tst_ack, no write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Copy command strobe |
| cmd_src | input | RAW | Source row number |
| cmd_dst | input | RAW | Destination row number |
| busy | output | 1 | Engine not in IDLE |
| done | output | 1 | One-cycle copy completion pulse |
| err | output | 1 | One-cycle rejection pulse (src equals dst) |
| tst_req | input | 1 | Single-bit test access request |
| tst_we | input | 1 | 1 writes the cell, 0 only reads it |
| tst_row | input | RAW | Test access row |
| tst_col | input | CAW | Test access column |
| tst_wbit | input | 1 | Bit written on a test write |
| tst_ack | output | 1 | Test access taken on the previous edge |
| tst_rdata | output | 1 | Prior value of the accessed cell, valid with tst_ack |

## Verification
A test access is taken on one edge, and its tst_ack and tst_rdata are due in the following cycle. For a copy, busy is due one cycle after the command edge, done exactly three cycles after it, and the destination row is complete at that same edge. A rejected command shows err one cycle after its edge and nothing after that. The bench drives every input on the falling edge and samples one falling edge per register stage. It reads busy, done and err at each of those four points, and reads the rows back only after busy has dropped.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SRC_OPEN = 3'd1,
        ST_DST_OPEN = 3'd2,
        ST_FINISH   = 3'd3,
        ST_REJECT   = 3'd4
    } rc_state_e;
endpackage

// File: rtl/rc_cell_array.sv
module rc_cell_array #(
    parameter int N_ROWS = 16,
    parameter int N_COLS = 16,
    localparam int RAW = $clog2(N_ROWS),
    localparam int CAW = $clog2(N_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_en,
    input  logic [RAW-1:0]    act_row,
    input  logic              wsel,
    input  logic [N_COLS-1:0] hold_row,
    input  logic              col_we,
    input  logic [CAW-1:0]    col_idx,
    input  logic              col_wbit,
    output logic [N_COLS-1:0] sense_row,
    output logic [N_COLS-1:0] latch_row
);
    logic [N_COLS-1:0] mem [N_ROWS];
    logic [N_COLS-1:0] wb_row;

    // Sensing is combinational on the opened row.
    assign sense_row = mem[act_row];

    // Write-back selector: the holding register when wsel is high,
    // otherwise the sensed row with an optional single-bit update.
    always_comb begin
        if (wsel) begin
            wb_row = hold_row;
        end else begin
            wb_row = sense_row;
            if (col_we) begin
                wb_row[col_idx] = col_wbit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (act_en) begin
            mem[act_row] <= wb_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_row <= '0;
        end else if (act_en) begin
            latch_row <= sense_row;
        end
    end
endmodule

// File: rtl/rc_hold_reg.sv
module rc_hold_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap_en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rc_seq.sv
module rc_seq
    import rowcopy_pkg::*;
#(
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [RAW-1:0] cmd_src,
    input  logic [RAW-1:0] cmd_dst,
    input  logic           tst_req,
    input  logic [RAW-1:0] tst_row,
    output logic           act_en,
    output logic [RAW-1:0] act_row,
    output logic           wsel,
    output logic           cap_en,
    output logic           tst_go,
    output logic           busy,
    output logic           done,
    output logic           err
);
    rc_state_e state_q, state_d;
    logic [RAW-1:0] src_q, dst_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = (cmd_src == cmd_dst) ? ST_REJECT : ST_SRC_OPEN;
                end
            end
            ST_SRC_OPEN: state_d = ST_DST_OPEN;
            ST_DST_OPEN: state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            ST_REJECT:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                src_q <= cmd_src;
                dst_q <= cmd_dst;
            end
        end
    end

    always_comb begin
        act_en  = 1'b0;
        act_row = tst_row;
        wsel    = 1'b0;
        cap_en  = 1'b0;
        tst_go  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        err     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                tst_go = tst_req && !cmd_valid;
                act_en = tst_req && !cmd_valid;
            end
            ST_SRC_OPEN: begin
                act_en  = 1'b1;
                act_row = src_q;
                cap_en  = 1'b1;
            end
            ST_DST_OPEN: begin
                act_en  = 1'b1;
                act_row = dst_q;
                wsel    = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            ST_REJECT: err  = 1'b1;
            default: busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/rowcopy_engine.sv
module rowcopy_engine #(
    parameter int N_ROWS = 16,
    parameter int N_COLS = 16,
    localparam int RAW = $clog2(N_ROWS),
    localparam int CAW = $clog2(N_COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [RAW-1:0] cmd_src,
    input  logic [RAW-1:0] cmd_dst,
    output logic           busy,
    output logic           done,
    output logic           err,
    input  logic           tst_req,
    input  logic           tst_we,
    input  logic [RAW-1:0] tst_row,
    input  logic [CAW-1:0] tst_col,
    input  logic           tst_wbit,
    output logic           tst_ack,
    output logic           tst_rdata
);
    logic              act_en, wsel, cap_en, tst_go;
    logic [RAW-1:0]    act_row;
    logic [N_COLS-1:0] sense_row, latch_row, hold_row;
    logic [CAW-1:0]    col_q;

    rc_seq #(.RAW(RAW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .tst_req(tst_req), .tst_row(tst_row),
        .act_en(act_en), .act_row(act_row), .wsel(wsel), .cap_en(cap_en),
        .tst_go(tst_go), .busy(busy), .done(done), .err(err)
    );

    rc_hold_reg #(.WIDTH(N_COLS)) u_hold (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .d(sense_row), .q(hold_row)
    );

    rc_cell_array #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_array (
        .clk(clk), .rst_n(rst_n),
        .act_en(act_en), .act_row(act_row), .wsel(wsel), .hold_row(hold_row),
        .col_we(tst_go && tst_we), .col_idx(tst_col), .col_wbit(tst_wbit),
        .sense_row(sense_row), .latch_row(latch_row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_ack <= 1'b0;
            col_q   <= '0;
        end else begin
            tst_ack <= tst_go;
            if (tst_go) begin
                col_q <= tst_col;
            end
        end
    end

    // The latch holds the row as sensed before the write-back.
    assign tst_rdata = latch_row[col_q];
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int RAW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [RAW-1:0] cmd_src,
    input logic [RAW-1:0] cmd_dst,
    input logic           tst_req,
    input logic           busy,
    input logic           done,
    input logic           err,
    input logic           tst_ack
);
    // R1
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> !done && !err && !tst_ack);

    // R2
    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_req && !busy && !cmd_valid) |=> tst_ack);

    // R4
    a_r4_done_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && $past(busy) && $past(busy, 2) && !$past(done));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_src != cmd_dst) |=> busy && !err && !done);

    // R7
    a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_src == cmd_dst) |=> err && busy && !done);

    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err && !busy && !done);

    // R8, R9
    a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tst_ack |-> !$past(busy) && !$past(cmd_valid));
endmodule

bind rowcopy_engine rc_checker #(.RAW(RAW)) u_rc_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .tst_req(tst_req), .busy(busy), .done(done),
    .err(err), .tst_ack(tst_ack)
);

// File: tb/test_rowcopy_engine.sv
`timescale 1ns/1ps
module test_rowcopy_engine;
    localparam int NR  = 16;
    localparam int NC  = 16;
    localparam int RAW = $clog2(NR);
    localparam int CAW = $clog2(NC);
    localparam int NV  = 8;
    // Each entry: {src, dst}
    localparam logic [7:0] VEC [NV] = '{
        8'h12, 8'h0F, 8'hF0, 8'h33, 8'h9A, 8'h21, 8'h5C, 8'hE7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [RAW-1:0] cmd_src = '0, cmd_dst = '0;
    logic busy, done, err, tst_ack, tst_rdata;
    logic tst_req = 1'b0, tst_we = 1'b0, tst_wbit = 1'b0;
    logic [RAW-1:0] tst_row = '0;
    logic [CAW-1:0] tst_col = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [NC-1:0] model [NR];

    always #2.5 clk = ~clk;

    rowcopy_engine #(.N_ROWS(NR), .N_COLS(NC)) i_rowcopy_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .busy(busy), .done(done), .err(err),
        .tst_req(tst_req), .tst_we(tst_we), .tst_row(tst_row),
        .tst_col(tst_col), .tst_wbit(tst_wbit), .tst_ack(tst_ack),
        .tst_rdata(tst_rdata)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] pat(input int r, input int seed);
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = (((r * 7 + c * 3 + (r ^ c) + seed) % 5) < 2);
        return v;
    endfunction

    task automatic access(input int r, input int c, input bit we, input bit wb,
                          output bit ack, output bit rd);
        @(negedge clk);
        tst_req = 1'b1; tst_we = we; tst_row = RAW'(r); tst_col = CAW'(c); tst_wbit = wb;
        @(negedge clk);
        tst_req = 1'b0; tst_we = 1'b0;
        ack = tst_ack; rd = tst_rdata;
    endtask

    task automatic write_row(input int r, input logic [NC-1:0] v);
        bit a, d;
        for (int c = 0; c < NC; c++) access(r, c, 1'b1, v[c], a, d);
        model[r] = v;
    endtask

    task automatic read_row(input int r, output logic [NC-1:0] v, output bit all_ack);
        bit a, d;
        all_ack = 1'b1;
        for (int c = 0; c < NC; c++) begin
            access(r, c, 1'b0, 1'b0, a, d);
            v[c] = d;
            all_ack &= a;
        end
    endtask

    task automatic check_row(input string req, input int r);
        logic [NC-1:0] v;
        bit a;
        read_row(r, v, a);
        chk(req, {a, v}, {1'b1, model[r]});
    endtask

    // Status packed as {busy, done, err}
    task automatic do_copy(input int s, input int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = RAW'(s); cmd_dst = RAW'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (s == d) begin
            chk("R7 reject pulse", {busy, done, err}, 3'b101);
            @(negedge clk);
            chk("R7 reject ends", {busy, done, err}, 3'b000);
        end else begin
            chk("R4 src open", {busy, done, err}, 3'b100);
            @(negedge clk);
            chk("R4 dst open", {busy, done, err}, 3'b100);
            @(negedge clk);
            chk("R4 finish", {busy, done, err}, 3'b110);
            @(negedge clk);
            chk("R4 back idle", {busy, done, err}, 3'b000);
            model[d] = model[s];
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a, d;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {busy, done, err, tst_ack}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {busy, done, err, tst_ack}, 4'b0000);

        for (int r = 0; r < NR; r++) write_row(r, pat(r, 0));

        // R2: a write returns the prior bit, then a read returns the new one
        access(3, 5, 1'b1, ~model[3][5], a, d);
        chk("R2 write ack and old bit", {a, d}, {1'b1, model[3][5]});
        model[3][5] = ~model[3][5];
        access(3, 5, 1'b0, 1'b0, a, d);
        chk("R2 read new bit", {a, d}, {1'b1, model[3][5]});
        check_row("R2 rest of row", 3);

        // Table-driven copies
        for (int i = 0; i < NV; i++) begin
            int s = int'(VEC[i][7:4]);
            int t = int'(VEC[i][3:0]);
            do_copy(s, t);
            if (s != t) begin
                check_row("R3 dst row", t);
                check_row("R5 src row", s);
                check_row("R5 other row", (t + 1) % NR);
            end else begin
                check_row("R7 row unchanged", s);
            end
        end

        // R6 and R8: second command and test write while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = 4'd1; cmd_dst = 4'd2;
        @(negedge clk);
        chk("R6 first started", {busy, done, err}, 3'b100);
        cmd_valid = 1'b1; cmd_src = 4'd3; cmd_dst = 4'd4;
        tst_req = 1'b1; tst_we = 1'b1; tst_row = 4'd5; tst_col = 4'd0; tst_wbit = ~model[5][0];
        @(negedge clk);
        chk("R8 no ack while busy", {tst_ack, busy, done}, 3'b010);
        @(negedge clk);
        chk("R6 done timing kept", {tst_ack, busy, done}, 3'b011);
        cmd_valid = 1'b0; tst_req = 1'b0; tst_we = 1'b0;
        @(negedge clk);
        chk("R6 no second copy", {busy, done, err}, 3'b000);
        model[2] = model[1];
        check_row("R6 first copy ok", 2);
        check_row("R6 ignored dst untouched", 4);
        check_row("R8 blocked write", 5);

        // R9: command and test access together in IDLE
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = 4'd6; cmd_dst = 4'd7;
        tst_req = 1'b1; tst_we = 1'b1; tst_row = 4'd8; tst_col = 4'd3; tst_wbit = ~model[8][3];
        @(negedge clk);
        cmd_valid = 1'b0; tst_req = 1'b0; tst_we = 1'b0;
        chk("R9 test dropped", {tst_ack, busy}, 2'b01);
        repeat (3) @(negedge clk);
        model[7] = model[6];
        check_row("R9 copy ran", 7);
        check_row("R9 no write", 8);

        // R3 with a second pattern set: copy top row to row 0
        write_row(NR - 1, pat(NR - 1, 3));
        do_copy(NR - 1, 0);
        check_row("R3 boundary rows", 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule